// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Advancing Pointer

This block answers on a two-wire serial bus as a target at one fixed 7-bit address. It holds a small bank of 8-bit registers. SCL and SDA come in as raw line levels. Each level passes through a two-flop synchronizer clocked by the system clock. Bus events are then decoded from the synchronized values. The block pulls SDA low through an open-drain enable and never drives the line high.

A controller first writes an index byte. That byte selects a register. Any following bytes in the same write land in successive registers. To read, the controller issues a repeated START with the read direction, and the block returns bytes starting at the selected register. An internal pointer moves forward by one after every byte transferred in either direction. It wraps at the end of the bank. The pointer survives both a repeated START and a STOP, so a read-only transaction continues from the last position.

Top module: `i2c_regfile_target`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts byte framing from any state, including partway through a byte, and the next eight bits are taken as an address byte.
- R2: A rising SDA while SCL is high (STOP) sends the block to idle with `sda_oe` low.
- R3: The address byte carries the target address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read), most significant bit first. With address `DEV_ADDR` (default 0x2A), the block holds SDA low during the ninth clock.
- R4: On an address mismatch the block does not acknowledge, never drives SDA until the next START, and changes neither a register nor its pointer.
- R5: In a write, the first byte after the address loads the pointer with its low log2(`NUM_REGS`) bits. This byte is acknowledged and writes no register.
- R6: Each later write byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R7: In a read, the block sends the register at the pointer MSB first, and the pointer advances by one after each byte.
- R8: In a read, a low level sampled in the ninth clock makes the block send the next register. A high level makes it release SDA until the next START.
- R9: The pointer wraps from `NUM_REGS`-1 to 0, both when writing and when reading.
- R10: The pointer keeps its value across a repeated START and across a STOP.
- R11: `sda_oe` changes only after an SCL falling edge (or on START/STOP), so SDA stays steady while SCL is high.
- R12: After reset, every register reads 0, the pointer is 0 and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1; released when 0 |

## Verification
The hardest states to reach are a START that cuts a byte in half and a pointer that has to survive several transactions. The bench sends four bits of a byte and then issues a repeated START. It then checks that a following indexed write and read-back work normally. For the pointer, a bench-side pointer model is carried through every STOP, repeated START, wrapping burst and ignored transfer. Each read-only transaction is compared against that model. The bench also sweeps every possible start index with a full-bank read, which crosses the wrap point at every offset.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_WR     = 3'd2,
    ST_RD     = 3'd3,
    ST_IGNORE = 3'd4
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Synchronizes both bus lines and derives bus events from the settled levels.
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [1:0] line_in;
  logic [1:0] line_sync;
  logic [1:0] line_prev;

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk) begin
      if (rst) ff_q <= '1;
      else     ff_q <= {ff_q[STAGES-2:0], line_in[g]};
    end
    assign line_sync[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) line_prev <= 2'b11;
    else     line_prev <= line_sync;
  end

  assign scl_lvl  = line_sync[1];
  assign sda_lvl  = line_sync[0];
  assign scl_rise = line_sync[1] & ~line_prev[1];
  assign scl_fall = ~line_sync[1] & line_prev[1];
  assign start_p  = line_sync[1] & line_prev[1] & line_prev[0] & ~line_sync[0];
  assign stop_p   = line_sync[1] & line_prev[1] & ~line_prev[0] & line_sync[0];
endmodule

// File: rtl/i2c_tgt_regs.sv
// Register bank: one write port, asynchronous read at the pointer.
module i2c_tgt_regs #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REGS = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int         AW      = $clog2(NUM_REGS);
  localparam int         BYTE_W  = 8;
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  tgt_state_e        st_q;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [AW-1:0]     ptr_q;
  logic              idx_pend_q, mack_q, oe_q;
  logic [BYTE_W-1:0] rd_data;
  logic [2:0]        tx_sel;
  logic              wr_en;
  logic              active;

  assign active = (st_q != ST_IDLE) && (st_q != ST_IGNORE);
  assign tx_sel = 3'(4'd7 - bit_q);
  assign wr_en  = active && !start_p && !stop_p && scl_fall &&
                  (st_q == ST_WR) && (bit_q == BIT_LAST) && !idx_pend_q;

  i2c_tgt_regs #(.DW(BYTE_W), .DEPTH(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(ptr_q), .wdata(rx_q),
    .raddr(ptr_q), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      bit_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      idx_pend_q <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
    end else if (start_p) begin
      st_q       <= ST_ADDR;
      bit_q      <= '0;
      oe_q       <= 1'b0;
      idx_pend_q <= 1'b1;
    end else if (stop_p) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      oe_q  <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_q < BIT_LAST) begin
          rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl};
          bit_q <= bit_q + 4'd1;
        end else if (bit_q == BIT_ACK) begin
          mack_q <= ~sda_lvl;
        end
      end else if (scl_fall) begin
        if (bit_q == BIT_LAST) begin
          bit_q <= BIT_ACK;
          case (st_q)
            ST_ADDR: begin
              if (rx_q[7:1] == DEV_ADDR) begin
                oe_q <= 1'b1;
                st_q <= rx_q[0] ? ST_RD : ST_WR;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
            ST_WR: begin
              oe_q <= 1'b1;
              if (idx_pend_q) begin
                ptr_q      <= rx_q[AW-1:0];
                idx_pend_q <= 1'b0;
              end else begin
                ptr_q <= ptr_q + AW'(1);
              end
            end
            ST_RD: begin
              oe_q  <= 1'b0;
              ptr_q <= ptr_q + AW'(1);
            end
            default: ;
          endcase
        end else if (bit_q == BIT_ACK) begin
          bit_q <= '0;
          if (st_q == ST_RD && mack_q) begin
            tx_q <= rd_data;
            oe_q <= ~rd_data[BYTE_W-1];
          end else begin
            oe_q <= 1'b0;
            if (st_q == ST_RD) st_q <= ST_IGNORE;
          end
        end else if (st_q == ST_RD && bit_q != '0) begin
          oe_q <= ~tx_q[tx_sel];
        end
      end
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_fall,
  input logic          start_p,
  input logic          stop_p,
  input logic          sda_oe,
  input logic [2:0]    st,
  input logic [3:0]    bit_cnt,
  input logic [AW-1:0] ptr
);
  import i2c_tgt_pkg::*;
  logic pv_q;
  always_ff @(posedge clk) begin
    if (rst) pv_q <= 1'b0;
    else     pv_q <= 1'b1;
  end

  // R11: the drive enable moves only after an SCL fall or a START/STOP
  p_oe_after_fall_r11: assert property (@(posedge clk) disable iff (rst)
    (pv_q && !$stable(sda_oe)) |-> $past(scl_fall || start_p || stop_p));

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> (st == 3'(ST_IDLE) && !sda_oe));

  p_start_frame_r1: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (st == 3'(ST_ADDR) && bit_cnt == 4'd0 && !sda_oe));

  p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (st == 3'(ST_IGNORE)) |-> !sda_oe);

  p_ptr_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (start_p || stop_p) |=> $stable(ptr));

  p_bit_range_r3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 4'd9);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_p(start_p),
  .stop_p(stop_p), .sda_oe(sda_oe), .st(st_q), .bit_cnt(bit_q), .ptr(ptr_q)
);

// File: tb/i2c_regfile_target_tb.sv
`timescale 1ns/1ps
module i2c_regfile_target_tb;
  localparam int         NREG = 8;
  localparam logic [6:0] DEV  = 7'h2A;
  localparam int         Q    = 10;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regfile_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int checks = 0, fails = 0, ptr_m = 0;
  bit finished = 1'b0;
  logic [7:0] model [NREG];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic w();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(); scl_m = 1'b1; w(); sda_m = 1'b0; w(); scl_m = 1'b0; w();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(); scl_m = 1'b1; w(); sda_m = 1'b1; w();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(); scl_m = 1'b1; w(); scl_m = 1'b0; w();
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; w(); scl_m = 1'b1; w();
    acked = !sda_line;
    w(); scl_m = 1'b0; w();
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b, output bit steady);
    logic early;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(); scl_m = 1'b1;
      repeat (4) @(posedge clk); #1;
      early = sda_line;
      w();
      b[i] = sda_line;
      if (early != b[i]) steady = 1'b0;
      scl_m = 1'b0; w();
    end
    sda_m = mack ? 1'b0 : 1'b1; w(); scl_m = 1'b1; w(); scl_m = 1'b0; w();
    sda_m = 1'b1;
  endtask

  // Read-only transaction of one byte from the current pointer
  task automatic read_one(input string tag);
    bit a, st; logic [7:0] d;
    bus_start();
    wbyte({DEV, 1'b1}, a);
    chk(a, {tag, " addr ack"}, a, 1);
    rbyte(1'b0, d, st);
    chk(d == model[ptr_m], tag, d, model[ptr_m]);
    bus_stop();
    ptr_m = (ptr_m + 1) % NREG;
  endtask

  initial begin
    bit a, st;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(posedge clk); #1;
    rst = 1'b0;
    w();
    chk(sda_oe == 1'b0, "R12 released after reset", sda_oe, 0);
    read_one("R12 reset register value");
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);

    // Burst write from index 5 across the wrap point
    bus_start();
    wbyte({DEV, 1'b0}, a);
    chk(a, "R3 write address ack", a, 1);
    wbyte(8'd5, a);
    chk(a, "R5 index byte ack", a, 1);
    for (int k = 0; k < NREG; k++) begin
      d = 8'(k * 37 + 11);
      wbyte(d, a);
      chk(a, "R6 data byte ack", a, 1);
      model[(5 + k) % NREG] = d;
    end
    bus_stop();
    ptr_m = (5 + NREG) % NREG;

    // Sweep all start indexes, full-bank read after repeated START
    for (int s = 0; s < NREG; s++) begin
      bus_start();
      wbyte({DEV, 1'b0}, a);
      wbyte(8'(s), a);
      bus_start();
      wbyte({DEV, 1'b1}, a);
      chk(a, "R3 read address ack after repeated start", a, 1);
      for (int j = 0; j < NREG; j++) begin
        rbyte(j < NREG - 1, d, st);
        chk(d == model[(s + j) % NREG], "R7 R9 read data", d, model[(s + j) % NREG]);
        chk(st, "R11 SDA steady while SCL high", st, 1);
      end
      chk(sda_oe == 1'b0, "R8 released after master NACK", sda_oe, 0);
      bus_stop();
      ptr_m = s;
    end

    // Pointer persists across STOP into read-only transactions
    read_one("R10 pointer after stop");
    read_one("R10 R9 pointer wraps across transactions");

    // Mismatched address: nothing acknowledged, nothing changed
    bus_start();
    wbyte({DEV ^ 7'h01, 1'b0}, a);
    chk(!a, "R4 mismatch address not acked", a, 0);
    wbyte(8'(ptr_m), a);
    chk(!a, "R4 mismatch index not acked", a, 0);
    wbyte(8'hFF, a);
    chk(!a, "R4 mismatch data not acked", a, 0);
    bus_stop();
    bus_start();
    wbyte({DEV ^ 7'h40, 1'b1}, a);
    chk(!a, "R4 mismatch read not acked", a, 0);
    bus_stop();
    read_one("R4 register and pointer untouched");

    // START partway through a byte restarts framing
    bus_start();
    send_bits(8'hA5, 4);
    bus_start();
    wbyte({DEV, 1'b0}, a);
    chk(a, "R1 address ack after mid-byte start", a, 1);
    wbyte(8'd2, a);
    wbyte(8'h5A, a);
    chk(a, "R1 data ack after mid-byte start", a, 1);
    model[2] = 8'h5A;
    bus_start();
    wbyte({DEV, 1'b0}, a);
    wbyte(8'd2, a);
    ptr_m = 2;
    bus_start();
    wbyte({DEV, 1'b1}, a);
    rbyte(1'b0, d, st);
    chk(d == 8'h5A, "R1 R10 read back after repeated start", d, 8'h5A);
    bus_stop();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule